// File: doc/BRIEF.md
# SIMD Scalar Lane Broadcast Unit

This unit takes one element out of a 64-bit source value and copies it into every lane of a vector result. The element can be 8, 16 or 32 bits wide. A single 4-bit field in the instruction word gives both the width and the position of the element: the lowest set bit of the field gives the width, and the bits above it give the index. Another instruction bit chooses whether the destination is a 64-bit or a 128-bit register.

The unit sits in the execute stage of a vector pipeline, after the source operand has been read. It sees every instruction that is issued with a valid strobe. It answers only the broadcast opcode. Each answer is registered and appears exactly one cycle later. The answer carries the replicated data, a flag saying that only the low 64 bits are to be written, and a flag for reserved encodings. Writing the register file is left to the caller.

Top module: `lane_bcast`

## Requirements
- R1: The unit claims an instruction only when instruction bits 11:7 equal 5'b11000. Any other value gives out_valid low in the following cycle.
- R2: When field bit 0 (instruction bit 16) is set, the element is 8 bits wide. It is read from source bits [8*k+7 : 8*k], where k is instruction bits 19:17.
- R3: When field bit 0 is clear and field bit 1 (instruction bit 17) is set, the element is 16 bits wide. It is read from source bits [16*k+15 : 16*k], where k is instruction bits 19:18.
- R4: When field bits 2:0 equal 3'b100, the element is 32 bits wide. It is read from source bits [32*k+31 : 32*k], where k is instruction bit 19.
- R5: The element is repeated to fill a 32-bit word, with lane 0 in the least significant bits. All four 32-bit words of out_data carry that same word.
- R6: out_half is high when instruction bit 6 is 0, meaning only out_data[63:0] is to be written. It is low when instruction bit 6 is 1, meaning all 128 bits are written.
- R7: A claimed instruction whose field bits 2:0 are all zero raises out_illegal, together with out_valid, and gives out_data equal to zero.
- R8: Results appear exactly one clock after the accepted strobe. In a cycle without in_valid the next cycle has out_valid low, and out_data keeps its value.
- R9: While rst_n is low at a clock edge, out_valid, out_illegal and out_data are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and source are valid this cycle |
| insn | input | 32 | Instruction word |
| src | input | 64 | Source register value |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 128 | Replicated result |
| out_half | output | 1 | Only the low 64 bits are to be written |
| out_illegal | output | 1 | Reserved size/index encoding |

## Verification
Directed cases walk every index for each element width. They use a source in which every byte is distinct, so a wrong offset, a wrong mask or a wrong width shows up as a wrong value. Reserved fields (0000 and 1000) and opcodes that are off by one bit separate rejection from acceptance. Idle cycles and a reset taken while the strobe is high check the latency and the hold rules. Seeded random instruction words and sources, with the opcode mostly forced, then mix all widths and both destination sizes against a bench model.

// File: rtl/lane_bcast_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the lane broadcast unit.
// Assumes the instruction bit positions below are fixed by the decoder upstream.
package lane_bcast_pkg;
    localparam int OPC_HI   = 11;
    localparam int OPC_LO   = 7;
    localparam logic [4:0] OPC_BCAST = 5'b11000;
    localparam int FLD_HI   = 19;
    localparam int FLD_LO   = 16;
    localparam int WIDE_BIT = 6;

    typedef enum logic [1:0] {
        ESZ_8    = 2'd0,
        ESZ_16   = 2'd1,
        ESZ_32   = 2'd2,
        ESZ_NONE = 2'd3
    } esz_t;
endpackage

// File: rtl/bcast_decode.sv
`timescale 1ns/1ps
// Module: bcast_decode
// Decodes the instruction word into: claim, element size, bit offset of the
// element in the source, destination width and the reserved flag.
// Assumes a source of at most 64 bits (offset fits OFS_W bits).
module bcast_decode
    import lane_bcast_pkg::*;
#(
    parameter int SRC_W = 64,
    localparam int OFS_W = $clog2(SRC_W)
) (
    input  logic [31:0]      insn,
    output logic             sel,
    output esz_t             esz,
    output logic [OFS_W-1:0] ofs,
    output logic             wide,
    output logic             reserved
);
    logic [FLD_HI-FLD_LO:0] fld;
    logic                   unused_bits;

    assign fld         = insn[FLD_HI:FLD_LO];
    assign sel         = (insn[OPC_HI:OPC_LO] == OPC_BCAST);
    assign wide        = insn[WIDE_BIT];
    assign unused_bits = ^{insn[31:20], insn[15:12], insn[5:0]};

    // Lowest set field bit selects width; the bits above it give the index.
    always_comb begin
        esz      = ESZ_NONE;
        ofs      = '0;
        reserved = 1'b0;
        if (fld[0]) begin
            esz = ESZ_8;
            ofs = OFS_W'({fld[3:1], 3'b000});
        end else if (fld[1]) begin
            esz = ESZ_16;
            ofs = OFS_W'({fld[3:2], 4'b0000});
        end else if (fld[2]) begin
            esz = ESZ_32;
            ofs = OFS_W'({fld[3], 5'b00000});
        end else begin
            reserved = 1'b1;
        end
    end
endmodule

// File: rtl/bcast_extract.sv
`timescale 1ns/1ps
// Module: bcast_extract
// Shifts the source right by the element offset and masks it to the element
// width. Assumes WORD_W is a multiple of 32 and SRC_W > WORD_W.
module bcast_extract
    import lane_bcast_pkg::*;
#(
    parameter int SRC_W  = 64,
    parameter int WORD_W = 32,
    localparam int OFS_W = $clog2(SRC_W)
) (
    input  logic [SRC_W-1:0]  src,
    input  esz_t              esz,
    input  logic [OFS_W-1:0]  ofs,
    output logic [WORD_W-1:0] elem
);
    logic [SRC_W-1:0] shifted;
    logic             unused_hi;

    assign shifted   = src >> ofs;
    assign unused_hi = ^shifted[SRC_W-1:WORD_W];

    // Keep only the element's own bits; upper bits read as zero.
    always_comb begin
        unique case (esz)
            ESZ_8:   elem = WORD_W'(shifted[7:0]);
            ESZ_16:  elem = WORD_W'(shifted[15:0]);
            ESZ_32:  elem = shifted[WORD_W-1:0];
            default: elem = '0;
        endcase
    end
endmodule

// File: rtl/bcast_fill.sv
`timescale 1ns/1ps
// Module: bcast_fill
// Repeats the element across a word, then the word across DST_WORDS words.
// Assumes WORD_W is a multiple of 16 and of 8.
module bcast_fill
    import lane_bcast_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int DST_WORDS = 4,
    localparam int DST_W    = WORD_W * DST_WORDS
) (
    input  logic [WORD_W-1:0] elem,
    input  esz_t              esz,
    output logic [DST_W-1:0]  data
);
    logic [WORD_W-1:0] word;

    // Build one word of repeated lanes for the chosen width.
    always_comb begin
        unique case (esz)
            ESZ_8:   word = {(WORD_W/8){elem[7:0]}};
            ESZ_16:  word = {(WORD_W/16){elem[15:0]}};
            default: word = elem;
        endcase
    end

    for (genvar w = 0; w < DST_WORDS; w++) begin : g_word
        assign data[w*WORD_W +: WORD_W] = word;
    end
endmodule

// File: rtl/lane_bcast.sv
`timescale 1ns/1ps
// Module: lane_bcast
// Top of the scalar lane broadcast unit: decode, extract, fill, then one
// register stage. Assumes the caller handles the register-file write and
// honours out_half. Reset is synchronous and active low.
module lane_bcast
    import lane_bcast_pkg::*;
#(
    parameter int SRC_W     = 64,
    parameter int WORD_W    = 32,
    parameter int DST_WORDS = 4,
    localparam int DST_W    = WORD_W * DST_WORDS,
    localparam int OFS_W    = $clog2(SRC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      insn,
    input  logic [SRC_W-1:0] src,
    output logic             out_valid,
    output logic [DST_W-1:0] out_data,
    output logic             out_half,
    output logic             out_illegal
);
    logic             sel;
    esz_t             esz;
    logic [OFS_W-1:0] ofs;
    logic             wide;
    logic             reserved;
    logic [WORD_W-1:0] elem;
    logic [DST_W-1:0]  filled;
    logic              take;

    bcast_decode #(.SRC_W(SRC_W)) u_dec (
        .insn     (insn),
        .sel      (sel),
        .esz      (esz),
        .ofs      (ofs),
        .wide     (wide),
        .reserved (reserved)
    );

    bcast_extract #(.SRC_W(SRC_W), .WORD_W(WORD_W)) u_ext (
        .src  (src),
        .esz  (esz),
        .ofs  (ofs),
        .elem (elem)
    );

    bcast_fill #(.WORD_W(WORD_W), .DST_WORDS(DST_WORDS)) u_fill (
        .elem (elem),
        .esz  (esz),
        .data (filled)
    );

    assign take = in_valid & sel;

    // Output stage: capture a claimed instruction, hold data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_half    <= 1'b0;
            out_data    <= '0;
        end else begin
            out_valid   <= take;
            out_illegal <= take & reserved;
            if (take) begin
                out_half <= ~wide;
                out_data <= reserved ? '0 : filled;
            end
        end
    end

    AST_CLAIM_OPC: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(insn[OPC_HI:OPC_LO]) == OPC_BCAST); // R1
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_data)); // R8
    AST_WORDS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data == {DST_WORDS{out_data[WORD_W-1:0]}}); // R5
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_valid && out_data == '0); // R7
    AST_HALF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_half == !$past(insn[WIDE_BIT])); // R6
    AST_SIZE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && sel |-> reserved == (esz == ESZ_NONE)); // R2
endmodule

// File: tb/sim_lane_bcast.sv
`timescale 1ns/1ps
module sim_lane_bcast;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [63:0]  src = '0;
    logic         out_valid;
    logic [127:0] out_data;
    logic         out_half;
    logic         out_illegal;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lane_bcast u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .src(src),
        .out_valid(out_valid), .out_data(out_data), .out_half(out_half),
        .out_illegal(out_illegal)
    );

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [3:0] f, logic q, logic [4:0] opc);
        logic [31:0] i;
        i = $urandom;
        i[11:7] = opc;
        i[19:16] = f;
        i[6] = q;
        return i;
    endfunction

    function automatic logic [127:0] model(logic [31:0] i, logic [63:0] s);
        logic [3:0] f;
        int w, k;
        logic [63:0] e;
        logic [31:0] word;
        f = i[19:16];
        if (f[0]) begin w = 8; k = int'(f >> 1); end
        else if (f[1]) begin w = 16; k = int'(f >> 2); end
        else if (f[2]) begin w = 32; k = int'(f >> 3); end
        else return '0;
        e = (s >> (w * k)) & ((64'd1 << w) - 64'd1);
        word = '0;
        for (int j = 0; j < 32 / w; j++) word = word | (e[31:0] << (j * w));
        return {4{word}};
    endfunction

    task automatic apply(logic [31:0] i, logic [63:0] s);
        logic claim, ill;
        string tag;
        claim = (i[11:7] == 5'b11000);
        ill = claim && (i[18:16] == 3'b000);
        if (i[16]) tag = "R2";
        else if (i[17]) tag = "R3";
        else if (i[18]) tag = "R4";
        else tag = "R7";
        @(negedge clk);
        in_valid = 1'b1; insn = i; src = s;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 valid", {127'd0, out_valid}, {127'd0, claim});
        if (claim) begin
            check("R7 illegal", {127'd0, out_illegal}, {127'd0, ill});
            check("R6 half", {127'd0, out_half}, {127'd0, ~i[6]});
            check(tag, out_data, model(i, s));
            check("R5 words", out_data, {4{out_data[31:0]}});
        end
    endtask

    initial begin
        logic [63:0] pat;
        logic [127:0] held;
        void'($urandom(32'd4242));
        pat = 64'h8877_6655_4433_2211;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {127'd0, out_valid}, 128'd0);
        check("R9 reset illegal", {127'd0, out_illegal}, 128'd0);
        check("R9 reset data", out_data, 128'd0);
        rst_n = 1'b1;
        // R2: every byte lane
        for (int k = 0; k < 8; k++) apply(mk({k[2:0], 1'b1}, 1'b1, 5'b11000), pat);
        // R3: every halfword lane
        for (int k = 0; k < 4; k++) apply(mk({k[1:0], 2'b10}, 1'b0, 5'b11000), pat);
        // R4: both word lanes
        apply(mk(4'b0100, 1'b1, 5'b11000), pat);
        apply(mk(4'b1100, 1'b0, 5'b11000), pat);
        // R7: reserved fields
        apply(mk(4'b0000, 1'b1, 5'b11000), pat);
        apply(mk(4'b1000, 1'b0, 5'b11000), pat);
        // R1: near-miss opcodes
        apply(mk(4'b0001, 1'b1, 5'b11001), pat);
        apply(mk(4'b0001, 1'b1, 5'b01000), pat);
        // R8: idle cycle keeps data, valid low
        apply(mk(4'b0011, 1'b1, 5'b11000), 64'hFEDC_BA98_7654_3210);
        held = out_data;
        @(negedge clk);
        src = ~src;
        insn = mk(4'b0101, 1'b1, 5'b11000);
        @(negedge clk);
        check("R8 idle valid", {127'd0, out_valid}, 128'd0);
        check("R8 idle hold", out_data, held);
        // R9: reset with strobe high
        in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset valid", {127'd0, out_valid}, 128'd0);
        check("R9 mid reset data", out_data, 128'd0);
        in_valid = 1'b0; rst_n = 1'b1;
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [4:0] opc;
            opc = ($urandom % 8 == 0) ? 5'($urandom) : 5'b11000;
            apply(mk(4'($urandom), 1'($urandom), opc), {$urandom, $urandom});
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule